// File: doc/BRIEF.md
# DMA list command sequencer

This block runs a scatter/gather list kept in local scratchpad memory. A list command gives a direction (get or put), a list address, a list length in bytes, a tag and a starting local address. The block fetches one 8-byte descriptor at a time over a synchronous read port with one cycle of latency. For each descriptor that carries a non-zero size, it presents one elementary transfer request to a downstream transfer engine. That request holds the external address, the size, the tag, the direction and a computed local address.

A descriptor can carry a stall-and-notify flag. The block then stops the list after that descriptor and sets the tag's bit in a stall status bitmask. It parks the list's resume point in a slot owned by that tag and accepts new commands again. A later acknowledge naming the tag restarts the parked list from the next descriptor. Software drains the stall bitmask with a read that clears it.

Top module: `dma_list_seq`

## Requirements
- R1: After reset, cmd_ready is 1, and xfer_valid, mem_rd_en, stat_valid and every bit of stat_bits are 0.
- R2: A descriptor is a 64-bit read word: bit 63 is the stall flag, bits 47:32 the transfer size and bits 31:0 the external address. A list holds floor(cmd_list_size / 8) descriptors. Descriptor i is read at byte address ((cmd_list_addr mod 2^18) with its low 3 bits cleared) + 8·i, taken mod 2^18; mem_rd_addr is that byte address divided by 8.
- R3: Transfers are issued in list order, one per descriptor of non-zero size. Each carries the command's direction and tag, the descriptor's external address and its size.
- R4: The running local address starts as cmd_lsa AND 0x3FFF0. Each transfer's local address is the running address OR external address bits 3:0. After a transfer, the running address grows by max(size, 16), mod 2^18.
- R5: A zero-size descriptor issues no transfer and leaves the running address alone. Its stall flag still takes effect.
- R6: After a descriptor whose stall flag is set, the list stops, and stat_bits[tag] becomes 1 in the same cycle the block stops. No further descriptor is read and cmd_ready returns to 1. The tag's slot saves the next descriptor address, the number of descriptors still to do and the running local address.
- R7: An acknowledge (ack_valid with ack_tag below 32) for a tag that holds a parked list restarts that list at the saved descriptor. The running address becomes the saved one AND 0x3FFF0, and the slot is freed. If nothing remains, no transfer is issued.
- R8: An acknowledge with ack_tag of 32 or more is ignored. So is one for a tag with no parked list. In both cases no transfer is issued, and cmd_ready stays 1 when the block is idle.
- R9: stat_valid is 1 when any stat_bits bit is 1. A cycle with stat_rd high clears, at the clock edge, every bit set before it. A bit set by a stall in that same cycle is kept.
- R10: cmd_ready is 0 while a list is being walked and while an acknowledged resume is waiting. A request with xfer_ready low keeps xfer_valid and its fields stable until accepted.
- R11: Acknowledged resumes run before new commands. When several are waiting, the lowest tag goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | List command present |
| cmd_ready | output | 1 | List command accepted when high with cmd_valid |
| cmd_put | input | 1 | Direction of the list: 1 put, 0 get |
| cmd_list_addr | input | 32 | Byte address of the list in local memory |
| cmd_list_size | input | 16 | List length in bytes |
| cmd_tag | input | 5 | Tag of the list |
| cmd_lsa | input | 18 | Starting local address |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 15 | Descriptor word address (byte address / 8) |
| mem_rd_data | input | 64 | Descriptor word, valid the cycle after mem_rd_en |
| xfer_valid | output | 1 | Elementary transfer request |
| xfer_ready | input | 1 | Transfer engine accepts the request |
| xfer_put | output | 1 | Direction of the transfer |
| xfer_tag | output | 5 | Tag of the transfer |
| xfer_lsa | output | 18 | Local address of the transfer |
| xfer_ea | output | 32 | External address of the transfer |
| xfer_size | output | 16 | Transfer size in bytes |
| ack_valid | input | 1 | Stall acknowledge strobe |
| ack_tag | input | 6 | Tag being acknowledged |
| stat_rd | input | 1 | Read-and-clear of the stall bitmask |
| stat_bits | output | 32 | Stall bitmask, bit per tag |
| stat_valid | output | 1 | Some stall bit is set |

## Verification
Recording a new stall and clearing the bitmask can both happen at one clock edge. The bench provokes this with a one-descriptor list whose only entry has size zero and the stall flag set. It counts the three register stages from command acceptance to the stop, and raises stat_rd for exactly the cycle in which the stop is recorded, while an older stall bit is already present. The bench then requires that only the new tag's bit remains. A second collision is an acknowledge arriving while another list is being walked: the resume must wait, be ordered by tag, and never overtake the running list.

// File: rtl/dls_pkg.sv
// Shared definitions for the DMA list sequencer.
// Assumes descriptors are read as one 64-bit word, flag word in the top half-word.
package dls_pkg;
    // Walker state: idle, issue read, capture descriptor, execute descriptor
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_FETCH = 2'd1,
        W_DESC  = 2'd2,
        W_EXEC  = 2'd3
    } walk_st_t;

    // Field widths of the flag half-word of a descriptor
    localparam int FLAGW_W = 16;
endpackage

// File: rtl/dls_walker.sv
// Descriptor walker: fetches descriptors one at a time, issues transfers,
// keeps the running local address and stops on a stall flag.
// Assumes a read port with one cycle of latency and one read outstanding.
module dls_walker
    import dls_pkg::*;
#(
    parameter int LS_AW = 18,
    parameter int EA_W  = 32,
    parameter int SZ_W  = 16,
    parameter int TAG_W = 5,
    localparam int CNT_W  = SZ_W - 3,
    localparam int DESC_W = FLAGW_W + SZ_W + EA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_put,
    input  logic [EA_W-1:0]   cmd_list_addr,
    input  logic [SZ_W-1:0]   cmd_list_size,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [LS_AW-1:0]  cmd_lsa,
    input  logic              res_req,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              res_put,
    input  logic [LS_AW-1:0]  res_addr,
    input  logic [CNT_W-1:0]  res_cnt,
    input  logic [LS_AW-1:0]  res_lsa,
    output logic              res_take,
    output logic              mem_rd_en,
    output logic [LS_AW-4:0]  mem_rd_addr,
    input  logic [DESC_W-1:0] mem_rd_data,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic              xfer_put,
    output logic [TAG_W-1:0]  xfer_tag,
    output logic [LS_AW-1:0]  xfer_lsa,
    output logic [EA_W-1:0]   xfer_ea,
    output logic [SZ_W-1:0]   xfer_size,
    output logic              save_en,
    output logic [TAG_W-1:0]  save_tag,
    output logic              save_put,
    output logic [LS_AW-1:0]  save_addr,
    output logic [CNT_W-1:0]  save_cnt,
    output logic [LS_AW-1:0]  save_lsa
);
    localparam int FLAG_BIT = DESC_W - 1;
    localparam int SZ_LO    = EA_W;

    walk_st_t         st;
    logic [LS_AW-1:0] cur_addr;
    logic [CNT_W-1:0] cnt;
    logic [LS_AW-1:0] run_lsa;
    logic             put_q;
    logic [TAG_W-1:0] tag_q;
    logic             d_flag;
    logic [SZ_W-1:0]  d_size;
    logic [EA_W-1:0]  d_ea;

    logic             load_res, load_cmd, step;
    logic [LS_AW-1:0] adv, nxt_lsa, nxt_addr;
    logic [CNT_W-1:0] nxt_cnt;
    logic             unused_bits;

    assign unused_bits = ^{cmd_list_addr[EA_W-1:LS_AW], cmd_list_addr[2:0],
                           res_addr[2:0], res_lsa[3:0], cmd_lsa[3:0],
                           mem_rd_data[FLAG_BIT-1:SZ_LO+SZ_W]};

    // Handshake decode for the start of a list
    always_comb begin
        load_res  = (st == W_IDLE) && res_req;
        load_cmd  = (st == W_IDLE) && !res_req && cmd_valid;
        cmd_ready = (st == W_IDLE) && !res_req;
        res_take  = load_res;
    end

    // Read port, request fields and step arithmetic
    always_comb begin
        mem_rd_en   = (st == W_FETCH);
        mem_rd_addr = cur_addr[LS_AW-1:3];
        xfer_valid  = (st == W_EXEC) && (d_size != '0);
        xfer_put    = put_q;
        xfer_tag    = tag_q;
        xfer_ea     = d_ea;
        xfer_size   = d_size;
        xfer_lsa    = run_lsa | {{(LS_AW-4){1'b0}}, d_ea[3:0]};
        step        = (st == W_EXEC) && ((d_size == '0) || xfer_ready);
        adv         = (d_size < SZ_W'(16)) ? LS_AW'(16) : LS_AW'(d_size);
        nxt_lsa     = (d_size == '0) ? run_lsa : run_lsa + adv;
        nxt_addr    = cur_addr + LS_AW'(8);
        nxt_cnt     = cnt - CNT_W'(1);
        save_en     = step && d_flag;
        save_tag    = tag_q;
        save_put    = put_q;
        save_addr   = nxt_addr;
        save_cnt    = nxt_cnt;
        save_lsa    = nxt_lsa;
    end

    // Walker state machine and list position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_IDLE;
            cur_addr <= '0;
            cnt      <= '0;
            run_lsa  <= '0;
            put_q    <= 1'b0;
            tag_q    <= '0;
            d_flag   <= 1'b0;
            d_size   <= '0;
            d_ea     <= '0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (load_res) begin
                        cur_addr <= {res_addr[LS_AW-1:3], 3'b000};
                        cnt      <= res_cnt;
                        run_lsa  <= {res_lsa[LS_AW-1:4], 4'h0};
                        put_q    <= res_put;
                        tag_q    <= res_tag;
                        st       <= (res_cnt != '0) ? W_FETCH : W_IDLE;
                    end else if (load_cmd) begin
                        cur_addr <= {cmd_list_addr[LS_AW-1:3], 3'b000};
                        cnt      <= cmd_list_size[SZ_W-1:3];
                        run_lsa  <= {cmd_lsa[LS_AW-1:4], 4'h0};
                        put_q    <= cmd_put;
                        tag_q    <= cmd_tag;
                        st       <= (cmd_list_size[SZ_W-1:3] != '0) ? W_FETCH : W_IDLE;
                    end
                end
                W_FETCH: st <= W_DESC;
                W_DESC: begin
                    d_flag <= mem_rd_data[FLAG_BIT];
                    d_size <= mem_rd_data[SZ_LO+SZ_W-1:SZ_LO];
                    d_ea   <= mem_rd_data[EA_W-1:0];
                    st     <= W_EXEC;
                end
                default: begin
                    if (step) begin
                        cur_addr <= nxt_addr;
                        cnt      <= nxt_cnt;
                        run_lsa  <= nxt_lsa;
                        st       <= (d_flag || (nxt_cnt == '0)) ? W_IDLE : W_FETCH;
                    end
                end
            endcase
        end
    end

    // R10: a waiting request keeps its fields
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_ea) &&
        $stable(xfer_lsa) && $stable(xfer_size) && $stable(xfer_tag));

    // R10: an accepted non-empty command makes the block busy
    p_busy_after_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_list_size >= SZ_W'(8)) |=> !cmd_ready);

    // R2: one descriptor read at a time
    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R6: nothing is read or issued right after a stall stop
    p_stop_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> !mem_rd_en && !xfer_valid);

    // R5: a zero-size descriptor never appears as a request
    p_no_empty_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_size != '0);
endmodule

// File: rtl/dls_stall_tbl.sv
// Stall table: one parked-list slot per tag, the pending-resume set filled
// by acknowledges, and the read-to-clear stall bitmask.
// Assumes save and take never hit the same tag in one cycle (walker is busy or idle).
module dls_stall_tbl #(
    parameter int LS_AW = 18,
    parameter int CNT_W = 13,
    parameter int TAG_W = 5,
    localparam int NTAG  = 1 << TAG_W,
    localparam int AID_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_en,
    input  logic [TAG_W-1:0] save_tag,
    input  logic             save_put,
    input  logic [LS_AW-1:0] save_addr,
    input  logic [CNT_W-1:0] save_cnt,
    input  logic [LS_AW-1:0] save_lsa,
    input  logic             ack_valid,
    input  logic [AID_W-1:0] ack_tag,
    output logic             res_req,
    output logic [TAG_W-1:0] res_tag,
    output logic             res_put,
    output logic [LS_AW-1:0] res_addr,
    output logic [CNT_W-1:0] res_cnt,
    output logic [LS_AW-1:0] res_lsa,
    input  logic             res_take,
    input  logic             stat_rd,
    output logic [NTAG-1:0]  stat_bits,
    output logic             stat_valid
);
    logic [NTAG-1:0]  slot_v;
    logic [NTAG-1:0]  slot_put;
    logic [LS_AW-1:0] slot_addr [NTAG];
    logic [CNT_W-1:0] slot_cnt  [NTAG];
    logic [LS_AW-1:0] slot_lsa  [NTAG];
    logic [NTAG-1:0]  pend;
    logic [NTAG-1:0]  stat;
    logic             ack_hit;
    logic [TAG_W-1:0] ack_idx;

    // Acknowledge qualification: in range and naming a parked list
    always_comb begin
        ack_idx = ack_tag[TAG_W-1:0];
        ack_hit = ack_valid && (ack_tag < AID_W'(NTAG)) && slot_v[ack_idx];
    end

    // Lowest pending tag wins the resume
    always_comb begin
        res_req = 1'b0;
        res_tag = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (pend[i]) begin
                res_req = 1'b1;
                res_tag = TAG_W'(i);
            end
        end
        res_put  = slot_put[res_tag];
        res_addr = slot_addr[res_tag];
        res_cnt  = slot_cnt[res_tag];
        res_lsa  = slot_lsa[res_tag];
    end

    assign stat_bits  = stat;
    assign stat_valid = |stat;

    // Slot, pending and status updates per tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v   <= '0;
            slot_put <= '0;
            pend     <= '0;
            stat     <= '0;
            for (int t = 0; t < NTAG; t++) begin
                slot_addr[t] <= '0;
                slot_cnt[t]  <= '0;
                slot_lsa[t]  <= '0;
            end
        end else begin
            for (int t = 0; t < NTAG; t++) begin
                if (save_en && (save_tag == TAG_W'(t))) begin
                    slot_v[t]    <= 1'b1;
                    slot_put[t]  <= save_put;
                    slot_addr[t] <= save_addr;
                    slot_cnt[t]  <= save_cnt;
                    slot_lsa[t]  <= save_lsa;
                end else if (res_take && (res_tag == TAG_W'(t))) begin
                    slot_v[t] <= 1'b0;
                end
                if (res_take && (res_tag == TAG_W'(t)))
                    pend[t] <= 1'b0;
                else if (ack_hit && (ack_idx == TAG_W'(t)))
                    pend[t] <= 1'b1;
                if (save_en && (save_tag == TAG_W'(t)))
                    stat[t] <= 1'b1;
                else if (stat_rd)
                    stat[t] <= 1'b0;
            end
        end
    end

    // R8: an out-of-range acknowledge adds no pending resume
    p_ack_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && (ack_tag >= AID_W'(NTAG)) && !res_take |=> $stable(pend));

    // R6: a stall always shows in the bitmask next cycle
    p_stall_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> stat_bits[$past(save_tag)]);

    // R9: a read with no new stall leaves the bitmask empty
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !save_en |=> stat_bits == '0 && !stat_valid);

    // R11: a resume is only taken while one is pending
    p_take_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_take |-> $countones(pend) >= 1);
endmodule

// File: rtl/dma_list_seq.sv
// DMA list command sequencer top: joins the descriptor walker to the
// per-tag stall table. Assumes an 8-byte descriptor word on the read port.
module dma_list_seq #(
    parameter int LS_AW = 18,
    parameter int EA_W  = 32,
    parameter int SZ_W  = 16,
    parameter int TAG_W = 5,
    localparam int CNT_W  = SZ_W - 3,
    localparam int NTAG   = 1 << TAG_W,
    localparam int DESC_W = dls_pkg::FLAGW_W + SZ_W + EA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_put,
    input  logic [EA_W-1:0]   cmd_list_addr,
    input  logic [SZ_W-1:0]   cmd_list_size,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [LS_AW-1:0]  cmd_lsa,
    output logic              mem_rd_en,
    output logic [LS_AW-4:0]  mem_rd_addr,
    input  logic [DESC_W-1:0] mem_rd_data,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic              xfer_put,
    output logic [TAG_W-1:0]  xfer_tag,
    output logic [LS_AW-1:0]  xfer_lsa,
    output logic [EA_W-1:0]   xfer_ea,
    output logic [SZ_W-1:0]   xfer_size,
    input  logic              ack_valid,
    input  logic [TAG_W:0]    ack_tag,
    input  logic              stat_rd,
    output logic [NTAG-1:0]   stat_bits,
    output logic              stat_valid
);
    logic             res_req, res_take, res_put, save_en, save_put;
    logic [TAG_W-1:0] res_tag, save_tag;
    logic [LS_AW-1:0] res_addr, res_lsa, save_addr, save_lsa;
    logic [CNT_W-1:0] res_cnt, save_cnt;

    dls_walker #(.LS_AW(LS_AW), .EA_W(EA_W), .SZ_W(SZ_W), .TAG_W(TAG_W)) i_walker (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_put(cmd_put),
        .cmd_list_addr(cmd_list_addr), .cmd_list_size(cmd_list_size),
        .cmd_tag(cmd_tag), .cmd_lsa(cmd_lsa),
        .res_req(res_req), .res_tag(res_tag), .res_put(res_put),
        .res_addr(res_addr), .res_cnt(res_cnt), .res_lsa(res_lsa),
        .res_take(res_take),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_put(xfer_put),
        .xfer_tag(xfer_tag), .xfer_lsa(xfer_lsa), .xfer_ea(xfer_ea),
        .xfer_size(xfer_size),
        .save_en(save_en), .save_tag(save_tag), .save_put(save_put),
        .save_addr(save_addr), .save_cnt(save_cnt), .save_lsa(save_lsa)
    );

    dls_stall_tbl #(.LS_AW(LS_AW), .CNT_W(CNT_W), .TAG_W(TAG_W)) i_stall_tbl (
        .clk(clk), .rst_n(rst_n),
        .save_en(save_en), .save_tag(save_tag), .save_put(save_put),
        .save_addr(save_addr), .save_cnt(save_cnt), .save_lsa(save_lsa),
        .ack_valid(ack_valid), .ack_tag(ack_tag),
        .res_req(res_req), .res_tag(res_tag), .res_put(res_put),
        .res_addr(res_addr), .res_cnt(res_cnt), .res_lsa(res_lsa),
        .res_take(res_take),
        .stat_rd(stat_rd), .stat_bits(stat_bits), .stat_valid(stat_valid)
    );
endmodule

// File: tb/test_dma_list_seq.sv
`timescale 1ns/1ps
module test_dma_list_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_put = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_list_addr = '0;
    logic [15:0] cmd_list_size = '0;
    logic [4:0]  cmd_tag = '0;
    logic [17:0] cmd_lsa = '0;
    logic        mem_rd_en;
    logic [14:0] mem_rd_addr;
    logic [63:0] mem_rd_data = '0;
    logic        xfer_valid, xfer_put;
    logic        xfer_ready = 1'b0;
    logic [4:0]  xfer_tag;
    logic [17:0] xfer_lsa;
    logic [31:0] xfer_ea;
    logic [15:0] xfer_size;
    logic        ack_valid = 1'b0;
    logic [5:0]  ack_tag = '0;
    logic        stat_rd = 1'b0;
    logic [31:0] stat_bits;
    logic        stat_valid;

    int checks = 0, errors = 0;
    bit hold_ready = 1'b0;

    logic [63:0] mem [512];
    logic [71:0] got [$];
    logic [71:0] exp_q [$];

    // bench model of the parked lists
    bit          m_v [32];
    bit          m_put [32];
    logic [17:0] m_addr [32];
    int          m_cnt [32];
    logic [17:0] m_lsa [32];
    logic [31:0] m_stat = '0;

    always #2 clk = ~clk;

    dma_list_seq i_dma_list_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_put(cmd_put), .cmd_list_addr(cmd_list_addr), .cmd_list_size(cmd_list_size),
        .cmd_tag(cmd_tag), .cmd_lsa(cmd_lsa), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_put(xfer_put), .xfer_tag(xfer_tag),
        .xfer_lsa(xfer_lsa), .xfer_ea(xfer_ea), .xfer_size(xfer_size),
        .ack_valid(ack_valid), .ack_tag(ack_tag), .stat_rd(stat_rd),
        .stat_bits(stat_bits), .stat_valid(stat_valid)
    );

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[8:0]];

    always @(posedge clk)
        if (rst_n && xfer_valid && xfer_ready)
            got.push_back({xfer_put, xfer_tag, xfer_lsa, xfer_ea, xfer_size});

    always @(negedge clk) xfer_ready <= hold_ready ? 1'b0 : (($urandom % 4) != 0);

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic put_desc(input int word, input bit fl, input logic [15:0] sz, input logic [31:0] ea);
        mem[word] = {fl, 15'h0, sz, ea};
    endtask

    // model: walk from a position, push expected transfers, park on stall
    task automatic model_walk(input bit put, input logic [4:0] tag, input logic [17:0] addr,
                              input int cnt, input logic [17:0] lsa);
        logic [63:0] d;
        lsa = lsa & 18'h3FFF0;
        addr = {addr[17:3], 3'b000};
        while (cnt > 0) begin
            d = mem[addr[11:3]];
            if (d[47:32] != 0) begin
                exp_q.push_back({put, tag, lsa | {14'h0, d[3:0]}, d[31:0], d[47:32]});
                lsa = lsa + ((d[47:32] < 16) ? 18'd16 : 18'(d[47:32]));
            end
            addr = addr + 18'd8;
            cnt--;
            if (d[63]) begin
                m_v[tag] = 1; m_put[tag] = put; m_addr[tag] = addr;
                m_cnt[tag] = cnt; m_lsa[tag] = lsa; m_stat[tag] = 1'b1;
                return;
            end
        end
    endtask

    task automatic model_resume(input logic [4:0] tag);
        if (m_v[tag]) begin
            m_v[tag] = 0;
            model_walk(m_put[tag], tag, m_addr[tag], m_cnt[tag], m_lsa[tag]);
        end
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic send(input bit put, input logic [4:0] tag, input logic [31:0] addr,
                        input logic [15:0] size, input logic [17:0] lsa);
        @(negedge clk);
        cmd_valid = 1; cmd_put = put; cmd_tag = tag;
        cmd_list_addr = addr; cmd_list_size = size; cmd_lsa = lsa;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic run_cmd(input bit put, input logic [4:0] tag, input logic [31:0] addr,
                           input logic [15:0] size, input logic [17:0] lsa);
        model_walk(put, tag, addr[17:0], int'(size) / 8, lsa);
        send(put, tag, addr, size, lsa);
        wait_idle();
    endtask

    task automatic ack(input logic [5:0] t);
        @(negedge clk);
        ack_valid = 1; ack_tag = t;
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic compare(input string req);
        chk(got.size() == exp_q.size(), {req, " count"}, 72'(got.size()), 72'(exp_q.size()));
        for (int i = 0; i < got.size() && i < exp_q.size(); i++)
            chk(got[i] == exp_q[i], req, got[i], exp_q[i]);
        got.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1 && !xfer_valid && !mem_rd_en, "R1 idle outputs",
            {cmd_ready, xfer_valid, mem_rd_en}, 72'b100);
        chk(stat_bits == 0 && !stat_valid, "R1 status", {stat_valid, stat_bits}, 72'h0);

        // R2 R3 R4 R5: masked list address, floor count, alignment, zero size
        put_desc(0, 0, 16'd20, 32'h1000_0005);
        put_desc(1, 0, 16'd0,  32'hDEAD_BEEF);
        put_desc(2, 0, 16'd4,  32'h0000_000A);
        put_desc(3, 0, 16'h40, 32'h2000_0003);
        put_desc(4, 0, 16'd8,  32'h7777_7777);
        run_cmd(1, 5'd2, 32'hFFFC_0000, 16'd37, 18'h1234F);
        compare("R2 R3 R4 R5 plain list");

        // R6: stall on second descriptor, tag 5
        put_desc(16, 0, 16'd24, 32'h0000_1001);
        put_desc(17, 1, 16'd24, 32'h0000_2002);
        put_desc(18, 0, 16'd16, 32'h0000_3003);
        put_desc(19, 0, 16'd3,  32'h0000_400F);
        run_cmd(0, 5'd5, 32'd128, 16'd32, 18'h00100);
        compare("R6 stop at flagged descriptor");
        chk(stat_bits == 32'h20 && stat_valid, "R6 stall bit", {stat_valid, stat_bits}, {1'b1, 32'h20});

        // R8: out-of-range and unmatched acknowledges are ignored
        ack(6'd37);
        repeat (8) @(negedge clk);
        chk(cmd_ready == 1 && got.size() == 0, "R8 tag 37 ignored", {cmd_ready, 32'(got.size())}, {1'b1, 32'h0});
        ack(6'd6);
        repeat (8) @(negedge clk);
        chk(cmd_ready == 1 && got.size() == 0, "R8 tag 6 without list", {cmd_ready, 32'(got.size())}, {1'b1, 32'h0});

        // R7: acknowledge resumes the tag 5 list
        model_resume(5'd5);
        ack(6'd5);
        wait_idle();
        compare("R7 resume");

        // R9: stall recorded in the very cycle of a status read
        put_desc(32, 1, 16'd0, 32'h0000_0000);
        chk(stat_valid == 1, "R9 prior bit present", 72'(stat_valid), 72'h1);
        @(negedge clk);
        cmd_valid = 1; cmd_put = 0; cmd_tag = 5'd9;
        cmd_list_addr = 32'd256; cmd_list_size = 16'd8; cmd_lsa = 18'h0;
        @(negedge clk);              // after acceptance edge
        cmd_valid = 0;
        @(negedge clk);              // after fetch edge
        @(negedge clk);              // after capture edge
        stat_rd = 1;
        @(negedge clk);              // after stop edge
        stat_rd = 0;
        chk(stat_bits == 32'h200, "R9 set wins over clear", 72'(stat_bits), 72'h200);
        model_walk(0, 5'd9, 18'd256, 1, 18'h0);
        m_stat = 32'h200;
        compare("R5 R9 zero-size stall issues nothing");
        @(negedge clk);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        chk(stat_bits == 0 && !stat_valid, "R9 read clears", {stat_valid, stat_bits}, 72'h0);
        m_stat = 0;
        model_resume(5'd9);
        ack(6'd9);
        wait_idle();
        compare("R7 resume with nothing left");

        // R11: two resumes queued behind a running list, lowest tag first
        put_desc(48, 1, 16'd32, 32'h0000_0700);
        put_desc(49, 0, 16'd32, 32'h0000_0701);
        run_cmd(1, 5'd7, 32'd384, 16'd16, 18'h2000);
        put_desc(56, 1, 16'd48, 32'h0000_0300);
        put_desc(57, 0, 16'd48, 32'h0000_0302);
        run_cmd(0, 5'd3, 32'd448, 16'd16, 18'h3000);
        compare("R6 two parked lists");
        put_desc(64, 0, 16'd16, 32'h0000_0100);
        put_desc(65, 0, 16'd16, 32'h0000_0110);
        put_desc(66, 0, 16'd16, 32'h0000_0120);
        hold_ready = 1;
        model_walk(1, 5'd1, 18'd512, 3, 18'h0);
        send(1, 5'd1, 32'd512, 16'd24, 18'h0);
        ack(6'd7);
        ack(6'd3);
        @(negedge clk);
        chk(cmd_ready == 0 && xfer_valid == 1, "R10 busy while walking and resumes waiting",
            {cmd_ready, xfer_valid}, 72'b01);
        model_resume(5'd3);
        model_resume(5'd7);
        hold_ready = 0;
        wait_idle();
        compare("R11 resume order");

        // random lists: R3 R4 R5 R6 R7
        for (int it = 0; it < 24; it++) begin
            int base, n;
            logic [4:0] tg;
            base = 80 + it * 8;
            n = 1 + ($urandom % 6);
            tg = 5'($urandom % 32);
            for (int k = 0; k < n; k++) begin
                int sel;
                logic [15:0] sz;
                sel = $urandom % 4;
                sz = (sel == 0) ? 16'd0 : (sel == 1) ? 16'(1 + $urandom % 30) :
                     (sel == 2) ? 16'd16 : 16'($urandom % 16384);
                put_desc(base + k, ($urandom % 4) == 0, sz, $urandom);
            end
            run_cmd($urandom % 2, tg, 32'(base * 8), 16'(n * 8 + ($urandom % 8)), 18'($urandom));
            while (m_v[tg]) begin
                model_resume(tg);
                ack({1'b0, tg});
                wait_idle();
            end
            compare("R3 R4 R5 R7 random list");
        end
        chk(stat_bits == m_stat, "R9 accumulated stall bits", 72'(stat_bits), 72'(m_stat));
        @(negedge clk);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        chk(stat_bits == 0, "R9 final clear", 72'(stat_bits), 72'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule